// File: doc/BRIEF.md
# Address Register with Region Decoder

This block holds the 16-bit address for a byte-wide memory system. It loads the address from two 8-bit bus halves and decodes the stored address into one of three regions: a program ROM in the lower half of the space, a 2K video RAM, and general SRAM covering the rest. For each region it drives active-low output-enable and write-enable lines.

The register loads only when the load control and the system-clock phase input are both high. If no source drives the high bus half, the upper address byte becomes 0x88. An instruction can then reach the SRAM zero page (0x8800 to 0x88FF) by supplying only the low byte. Reads enable the selected region's output at once. Writes produce a delayed, shortened write-enable pulse, timed in fast-clock cycles, so that the data is settled before the memory writes it. The ROM can be written only while the program-enable input is high.

Top module: `addr_region_ctrl`

## Requirements
- R1: After reset `addr` is 0x0000, `region_sel` is 3'b001 (ROM), and all six enable outputs are high.
- R2: `addr` is updated on a clock edge only when `load_en` and `phase_hi` are both high. At every other edge it holds its value. On a load, the low byte takes `bus_lo`.
- R3: On a load with `hi_bus_driven` high, the upper byte takes `bus_hi`. With `hi_bus_driven` low, the upper byte becomes 0x88 whatever `bus_hi` carries.
- R4: `region_sel` is one-hot with bit 0 = ROM, bit 1 = video RAM, bit 2 = SRAM. Addresses 0x0000 to 0x7FFF select ROM.
- R5: Addresses 0x8000 to 0x87FF select video RAM (`region_sel` = 3'b010).
- R6: Addresses 0x8800 to 0xFFFF select SRAM (`region_sel` = 3'b100).
- R7: While `rd_strobe` and `phase_hi` are high and `wr_strobe` is low, the selected region's output-enable is low and the other two are high. The output-enable responds in the same cycle. In every other case all output-enables are high.
- R8: A write starts at the first clock edge where `wr_strobe` and `phase_hi` are both high. The selected region's write-enable then goes low WE_DELAY edges later (default 2) and stays low for WE_WIDTH edges (default 3). It then returns high while the strobe is still held.
- R9: The region used by a write is captured at its start edge. A write to the ROM region leaves `rom_we_n` high unless `prog_en` was high at that start edge.
- R10: If `wr_strobe` or `phase_hi` is low at an edge, all write-enables are high after that edge. This cuts short any pulse in progress.
- R11: An output-enable and a write-enable are never low together, and at most one write-enable is low at a time.
- R12: A held write strobe yields a single pulse. A new pulse needs the strobe to be removed and applied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that times the write pulse |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_hi | input | 1 | System clock phase level; qualifies loads and strobes |
| load_en | input | 1 | Address load control |
| hi_bus_driven | input | 1 | High when a source drives `bus_hi` |
| bus_lo | input | 8 | Low bus half |
| bus_hi | input | 8 | High bus half |
| rd_strobe | input | 1 | Data-out (read) strobe |
| wr_strobe | input | 1 | Data-in (write) strobe |
| prog_en | input | 1 | Permits writes to the ROM region |
| addr | output | 16 | Stored address |
| region_sel | output | 3 | One-hot region select (ROM, video RAM, SRAM) |
| rom_oe_n | output | 1 | ROM output-enable, active low |
| rom_we_n | output | 1 | ROM write-enable, active low |
| vram_oe_n | output | 1 | Video RAM output-enable, active low |
| vram_we_n | output | 1 | Video RAM write-enable, active low |
| sram_oe_n | output | 1 | SRAM output-enable, active low |
| sram_we_n | output | 1 | SRAM write-enable, active low |

## Verification
A corrupted stored address shows on `addr` and `region_sel` one edge after the bad load, because both are visible at the ports. A wrong write sequencer state or count shows as a write-enable edge one or more cycles off the expected window. A pulse that fails to end, or one that repeats under a held strobe, shows within WE_DELAY + WE_WIDTH + 1 cycles. A wrongly captured write region or ROM gate shows as a pulse on the wrong enable line in that same window.

// File: rtl/addr_region_pkg.sv
// Shared constants and types for the address register and region decoder.
// Assumes three regions, indexed as below in every one-hot vector.
package addr_region_pkg;

    localparam int RGN_ROM   = 0;
    localparam int RGN_VRAM  = 1;
    localparam int RGN_SRAM  = 2;
    localparam int RGN_COUNT = 3;

    // Write pulse sequencer states
    typedef enum logic [1:0] {
        WP_IDLE  = 2'd0,
        WP_WAIT  = 2'd1,
        WP_PULSE = 2'd2,
        WP_DONE  = 2'd3
    } wp_state_t;

endpackage

// File: rtl/addr_latch.sv
// Address register: loads the low and high bytes together when the load
// control and clock phase are both high. The zero-page byte replaces the
// high bus value when no source drives that bus.
// Assumes bus inputs are stable around the qualifying clock edge.
module addr_latch #(
    parameter int          BYTE_W    = 8,
    parameter logic [7:0]  ZP_HI     = 8'h88,
    localparam int         ADDR_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_hi,
    input  logic              load_en,
    input  logic              hi_bus_driven,
    input  logic [BYTE_W-1:0] bus_lo,
    input  logic [BYTE_W-1:0] bus_hi,
    output logic [ADDR_W-1:0] addr
);

    logic              load_now;
    logic [BYTE_W-1:0] hi_src;

    // Qualify the load with the clock phase
    assign load_now = load_en & phase_hi;

    // Pick the high byte source: bus or zero-page default
    always_comb begin
        hi_src = hi_bus_driven ? bus_hi : BYTE_W'(ZP_HI);
    end

    // Store both bytes on a qualified edge, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_now) begin
            addr <= {hi_src, bus_lo};
        end
    end

endmodule

// File: rtl/region_decode.sv
// Combinational decoder from address to one-hot region select.
// Assumes ROM_END < VRAM_END; everything above VRAM_END is SRAM.
module region_decode
    import addr_region_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [15:0]     ROM_END  = 16'h7FFF,
    parameter logic [15:0]     VRAM_END = 16'h87FF
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [RGN_COUNT-1:0] region_sel
);

    // Compare the address against the two region boundaries
    always_comb begin
        region_sel = '0;
        if (addr <= ADDR_W'(ROM_END)) begin
            region_sel[RGN_ROM] = 1'b1;
        end else if (addr <= ADDR_W'(VRAM_END)) begin
            region_sel[RGN_VRAM] = 1'b1;
        end else begin
            region_sel[RGN_SRAM] = 1'b1;
        end
    end

endmodule

// File: rtl/strobe_gen.sv
// Builds active-low output and write enables per region. Reads are
// combinational. Writes run a sequencer that waits WE_DELAY edges, then holds
// the write enable low for WE_WIDTH edges, once per strobe.
// Assumes WE_DELAY >= 1 and WE_WIDTH >= 1, and a stable address during writes.
module strobe_gen
    import addr_region_pkg::*;
#(
    parameter int  WE_DELAY = 2,
    parameter int  WE_WIDTH = 3,
    localparam int CNT_MAX  = (WE_DELAY > WE_WIDTH) ? WE_DELAY : WE_WIDTH,
    localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 phase_hi,
    input  logic                 rd_strobe,
    input  logic                 wr_strobe,
    input  logic                 prog_en,
    input  logic [RGN_COUNT-1:0] region_sel,
    output logic [RGN_COUNT-1:0] oe_n,
    output logic [RGN_COUNT-1:0] we_n
);

    wp_state_t            state;
    logic [CNT_W-1:0]     cnt;
    logic [RGN_COUNT-1:0] wr_region;
    logic [RGN_COUNT-1:0] wr_allowed;
    logic                 wr_act;
    logic                 rd_ok;

    // Qualified strobes
    assign wr_act = wr_strobe & phase_hi;
    assign rd_ok  = rd_strobe & phase_hi & ~wr_strobe;

    // Mask the ROM bit unless programming is enabled
    always_comb begin
        wr_allowed          = region_sel;
        wr_allowed[RGN_ROM] = region_sel[RGN_ROM] & prog_en;
    end

    // Write pulse sequencer: wait, pulse, then hold until strobe ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WP_IDLE;
            cnt       <= '0;
            wr_region <= '0;
        end else if (!wr_act) begin
            state     <= WP_IDLE;
            cnt       <= '0;
        end else begin
            unique case (state)
                WP_IDLE: begin
                    state     <= WP_WAIT;
                    cnt       <= CNT_W'(WE_DELAY - 1);
                    wr_region <= wr_allowed;
                end
                WP_WAIT: begin
                    if (cnt == '0) begin
                        state <= WP_PULSE;
                        cnt   <= CNT_W'(WE_WIDTH - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                WP_PULSE: begin
                    if (cnt == '0) begin
                        state <= WP_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= WP_DONE;
                end
            endcase
        end
    end

    // One enable pair per region
    for (genvar g = 0; g < RGN_COUNT; g++) begin : g_rgn
        assign oe_n[g] = ~(region_sel[g] & rd_ok);
        assign we_n[g] = ~((state == WP_PULSE) & wr_region[g]);
    end

endmodule

// File: rtl/addr_region_ctrl.sv
// Top: address register, region decoder and enable generator.
// Assumes a single fast clock with phase_hi carrying the slower system phase.
module addr_region_ctrl
    import addr_region_pkg::*;
#(
    parameter int          WE_DELAY = 2,
    parameter int          WE_WIDTH = 3,
    parameter logic [7:0]  ZP_HI    = 8'h88
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phase_hi,
    input  logic        load_en,
    input  logic        hi_bus_driven,
    input  logic [7:0]  bus_lo,
    input  logic [7:0]  bus_hi,
    input  logic        rd_strobe,
    input  logic        wr_strobe,
    input  logic        prog_en,
    output logic [15:0] addr,
    output logic [2:0]  region_sel,
    output logic        rom_oe_n,
    output logic        rom_we_n,
    output logic        vram_oe_n,
    output logic        vram_we_n,
    output logic        sram_oe_n,
    output logic        sram_we_n
);

    logic [RGN_COUNT-1:0] oe_n;
    logic [RGN_COUNT-1:0] we_n;

    addr_latch #(.BYTE_W(8), .ZP_HI(ZP_HI)) u_latch (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_hi      (phase_hi),
        .load_en       (load_en),
        .hi_bus_driven (hi_bus_driven),
        .bus_lo        (bus_lo),
        .bus_hi        (bus_hi),
        .addr          (addr)
    );

    region_decode #(.ADDR_W(16)) u_dec (
        .addr       (addr),
        .region_sel (region_sel)
    );

    strobe_gen #(.WE_DELAY(WE_DELAY), .WE_WIDTH(WE_WIDTH)) u_strb (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_hi   (phase_hi),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .prog_en    (prog_en),
        .region_sel (region_sel),
        .oe_n       (oe_n),
        .we_n       (we_n)
    );

    // Map region vectors onto named pins
    assign rom_oe_n  = oe_n[RGN_ROM];
    assign rom_we_n  = we_n[RGN_ROM];
    assign vram_oe_n = oe_n[RGN_VRAM];
    assign vram_we_n = we_n[RGN_VRAM];
    assign sram_oe_n = oe_n[RGN_SRAM];
    assign sram_we_n = we_n[RGN_SRAM];

endmodule

// File: rtl/addr_region_chk.sv
// Checker for addr_region_ctrl, attached by bind. Observes ports only.
module addr_region_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        phase_hi,
    input logic        load_en,
    input logic        hi_bus_driven,
    input logic        rd_strobe,
    input logic        wr_strobe,
    input logic [15:0] addr,
    input logic [2:0]  region_sel,
    input logic        rom_oe_n,
    input logic        rom_we_n,
    input logic        vram_oe_n,
    input logic        vram_we_n,
    input logic        sram_oe_n,
    input logic        sram_we_n
);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && phase_hi) |=> $stable(addr));

    // R3
    zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && phase_hi && !hi_bus_driven) |=> (addr[15:8] == 8'h88));

    // R4
    region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(region_sel));

    // R7
    rom_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && phase_hi && !wr_strobe && region_sel[0]) |-> !rom_oe_n);

    // R10
    we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && phase_hi) |=> (rom_we_n && vram_we_n && sram_we_n));

    // R11
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((!rom_oe_n || !vram_oe_n || !sram_oe_n) &&
          (!rom_we_n || !vram_we_n || !sram_we_n)));

    // R11
    single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rom_we_n, vram_we_n, sram_we_n}) >= 2);

endmodule

bind addr_region_ctrl addr_region_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase_hi      (phase_hi),
    .load_en       (load_en),
    .hi_bus_driven (hi_bus_driven),
    .rd_strobe     (rd_strobe),
    .wr_strobe     (wr_strobe),
    .addr          (addr),
    .region_sel    (region_sel),
    .rom_oe_n      (rom_oe_n),
    .rom_we_n      (rom_we_n),
    .vram_oe_n     (vram_oe_n),
    .vram_we_n     (vram_we_n),
    .sram_oe_n     (sram_oe_n),
    .sram_we_n     (sram_we_n)
);

// File: tb/addr_region_ctrl_bench.sv
// Directed bench for addr_region_ctrl. Inputs change after the falling edge;
// outputs are sampled just before the next rising edge.
module addr_region_ctrl_bench;

    localparam int WE_DELAY = 2;
    localparam int WE_WIDTH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_hi = 1'b0;
    logic        load_en = 1'b0;
    logic        hi_bus_driven = 1'b1;
    logic [7:0]  bus_lo = '0;
    logic [7:0]  bus_hi = '0;
    logic        rd_strobe = 1'b0;
    logic        wr_strobe = 1'b0;
    logic        prog_en = 1'b0;
    logic [15:0] addr;
    logic [2:0]  region_sel;
    logic        rom_oe_n, rom_we_n, vram_oe_n, vram_we_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    addr_region_ctrl #(.WE_DELAY(WE_DELAY), .WE_WIDTH(WE_WIDTH)) u_addr_region_ctrl (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi), .load_en(load_en),
        .hi_bus_driven(hi_bus_driven), .bus_lo(bus_lo), .bus_hi(bus_hi),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .prog_en(prog_en),
        .addr(addr), .region_sel(region_sel),
        .rom_oe_n(rom_oe_n), .rom_we_n(rom_we_n),
        .vram_oe_n(vram_oe_n), .vram_we_n(vram_we_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one rising edge; return after the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_addr(input logic [7:0] lo, input logic [7:0] hi, input logic drv);
        load_en = 1'b1; phase_hi = 1'b1; bus_lo = lo; bus_hi = hi; hi_bus_driven = drv;
        step();
        load_en = 1'b0; phase_hi = 1'b0; hi_bus_driven = 1'b1;
    endtask

    function automatic logic [2:0] exp_region(input logic [15:0] a);
        if (a < 16'h8000) return 3'b001;
        if (a < 16'h8800) return 3'b010;
        return 3'b100;
    endfunction

    task automatic t_reset();
        // R1
        check("R1 addr", addr, 16'h0000);
        check("R1 region", {13'b0, region_sel}, 16'h0001);
        check("R1 enables", {10'b0, rom_oe_n, rom_we_n, vram_oe_n, vram_we_n, sram_oe_n, sram_we_n}, 16'h003F);
    endtask

    task automatic t_load_gating();
        // R2: load control alone, then phase alone, do not load
        load_addr(8'h34, 8'h12, 1'b1);
        check("R2 load", addr, 16'h1234);
        load_en = 1'b1; bus_lo = 8'hAA; bus_hi = 8'hBB; step();
        check("R2 no phase", addr, 16'h1234);
        load_en = 1'b0; phase_hi = 1'b1; step();
        check("R2 no load", addr, 16'h1234);
        phase_hi = 1'b0;
    endtask

    task automatic t_zero_page();
        // R3
        load_addr(8'h5C, 8'h3F, 1'b0);
        check("R3 zp addr", addr, 16'h885C);
        check("R3 zp region", {13'b0, region_sel}, 16'h0004);
        load_addr(8'h01, 8'hC7, 1'b1);
        check("R3 driven", addr, 16'hC701);
    endtask

    task automatic t_decode();
        // R4 R5 R6 boundaries
        logic [15:0] pts [8] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h87FF,
                                 16'h8800, 16'hFFFF, 16'h4321, 16'h8123};
        for (int i = 0; i < 8; i++) begin
            load_addr(pts[i][7:0], pts[i][15:8], 1'b1);
            check(pts[i] < 16'h8000 ? "R4 rom" : (pts[i] < 16'h8800 ? "R5 vram" : "R6 sram"),
                  {13'b0, region_sel}, {13'b0, exp_region(pts[i])});
        end
    endtask

    task automatic t_read();
        // R7
        load_addr(8'h10, 8'h84, 1'b1);
        rd_strobe = 1'b1; phase_hi = 1'b1; #1;
        check("R7 vram oe", {13'b0, rom_oe_n, vram_oe_n, sram_oe_n}, 16'h0005);
        phase_hi = 1'b0; #1;
        check("R7 phase low", {13'b0, rom_oe_n, vram_oe_n, sram_oe_n}, 16'h0007);
        phase_hi = 1'b1; wr_strobe = 1'b1; #1;
        check("R7 write blocks oe", {13'b0, rom_oe_n, vram_oe_n, sram_oe_n}, 16'h0007);
        rd_strobe = 1'b0; wr_strobe = 1'b0; phase_hi = 1'b0;
        step();
    endtask

    // Hold a write for n samples; record we_n triplet per sample; drop at abort_at (0 = never)
    task automatic run_write(input string tag, input int n, input int abort_at,
                             input logic [2:0] pulse_mask);
        logic [2:0] exp_we;
        logic       low_now;
        phase_hi = 1'b1; wr_strobe = 1'b1;
        for (int i = 1; i <= n; i++) begin
            step();
            low_now = (i >= WE_DELAY + 1) && (i <= WE_DELAY + WE_WIDTH)
                      && (abort_at == 0 || i <= abort_at);
            exp_we = low_now ? ~pulse_mask : 3'b111;
            check(tag, {13'b0, sram_we_n, vram_we_n, rom_we_n}, {13'b0, exp_we});
            if (i == abort_at) wr_strobe = 1'b0;
        end
        wr_strobe = 1'b0; phase_hi = 1'b0;
        step();
    endtask

    task automatic t_write_pulse();
        // R8: SRAM write window; R12: held strobe gives one pulse
        load_addr(8'h00, 8'h90, 1'b1);
        run_write("R8 sram pulse", 6, 0, 3'b100);
        run_write("R12 single pulse", 12, 0, 3'b100);
        load_addr(8'h00, 8'h80, 1'b1);
        run_write("R8 vram pulse", 6, 0, 3'b010);
    endtask

    task automatic t_rom_write();
        // R9
        load_addr(8'h00, 8'h10, 1'b1);
        prog_en = 1'b0;
        run_write("R9 rom locked", 7, 0, 3'b000);
        prog_en = 1'b1;
        run_write("R9 rom programmed", 7, 0, 3'b001);
        prog_en = 1'b0;
    endtask

    task automatic t_abort();
        // R10: drop strobe after first low sample
        load_addr(8'h00, 8'hA0, 1'b1);
        run_write("R10 abort", 6, WE_DELAY + 1, 3'b100);
    endtask

    task automatic t_exclusive();
        // R11: read and write together never enable both
        load_addr(8'h00, 8'hB0, 1'b1);
        rd_strobe = 1'b1; phase_hi = 1'b1; wr_strobe = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            check("R11 excl", {15'b0, (~&{rom_oe_n, vram_oe_n, sram_oe_n}) &&
                                      (~&{rom_we_n, vram_we_n, sram_we_n})}, 16'h0000);
        end
        rd_strobe = 1'b0; wr_strobe = 1'b0; phase_hi = 1'b0;
        step();
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_load_gating();
        t_zero_page();
        t_decode();
        t_read();
        t_write_pulse();
        t_rom_write();
        t_abort();
        t_exclusive();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule